// File: doc/BRIEF.md
# Two-Channel Transfer Control and Status Registers

This block is the register pair that software uses to steer a two-channel data-flow transfer engine and to watch it. A control register holds, for each channel, an abort command, an end-of-flow interrupt enable and an interrupt acknowledge command. A read-only status register shows, for each channel, whether a transfer is busy, whether the source and destination peripherals are ready, and whether the channel has finished a flow and is still waiting to be acknowledged.

The engine drives per-channel busy, source-ready, destination-ready and end-of-transfer inputs. In return the block gives a one-cycle abort pulse per channel and one level-sensitive interrupt request. Accesses arrive on a plain 8-bit register port with a write strobe and a one-bit register select. Reads are combinational.

Top module: `xfer_csr`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00, `irq` is 0 and `abort_pulse` is 0.
- R2: The control register (select 0) reads enable bits at positions 6 (channel 1) and 2 (channel 0) back as written. Acknowledge bits 5 and 1 and reserved bits 4 and 0 always read 0.
- R3: A control write with bit 7 (channel 1) or bit 3 (channel 0) at 1 drives that channel's `abort_pulse` high for exactly the one cycle after the write edge. The bit reads 0 from the following cycle on. A 0 in that bit gives no pulse.
- R4: A high `chan_done[c]` sampled on a clock edge sets channel c's end-of-flow flag. The flag reads at status bit 5 (channel 1) or bit 1 (channel 0) and stays set.
- R5: A control write with bit 5 (channel 1) or bit 1 (channel 0) at 1 clears that channel's flag. A 0 in that bit leaves the flag unchanged.
- R6: No software write can set a flag. This covers any value written to the status register (select 1) and any control write.
- R7: Status bits 3/2/0 (channel 0) and 7/6/4 (channel 1) show destination-ready, source-ready and busy straight from the inputs, in the same cycle.
- R8: `irq` is high exactly while some channel has both its flag and its enable set. Clearing the enable masks the request without clearing the flag.
- R9: If `chan_done[c]` and an acknowledge for channel c fall on the same edge, the flag ends up set.
- R10: An acknowledge or abort aimed at one channel leaves the other channel's flag and abort output alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| chan_busy | input | 2 | Per-channel transfer in progress |
| chan_src_rdy | input | 2 | Per-channel source peripheral ready |
| chan_dst_rdy | input | 2 | Per-channel destination peripheral ready |
| chan_done | input | 2 | Per-channel end-of-transfer event |
| abort_pulse | output | 2 | Per-channel one-cycle abort command |
| irq | output | 1 | Combined interrupt request |

## Verification
A flag that is stuck or lost shows up on the status read and on `irq` one cycle after the event or acknowledge that should have moved it. A wrong enable is seen on the control readback and as a missing or spurious `irq` in the same cycle. An abort that is held too long or fires on the wrong channel is visible on `abort_pulse` within two cycles of the write. Mixed-up bit positions show on the very first read after the stimulus, because every field is checked against its numeric position.

// File: rtl/xfer_csr_pkg.sv
// Package: shared field offsets and register selects for the transfer CSR.
// Assumes each channel owns one 4-bit field in both registers.
package xfer_csr_pkg;
    localparam int FIELD_W    = 4;
    // control field offsets inside one channel nibble
    localparam int C_ABORT    = 3;
    localparam int C_ENABLE   = 2;
    localparam int C_ACK      = 1;
    // status field offsets inside one channel nibble
    localparam int S_DST      = 3;
    localparam int S_SRC      = 2;
    localparam int S_FLAG     = 1;
    localparam int S_BUSY     = 0;
    localparam logic SEL_CTL  = 1'b0;
    localparam logic SEL_STAT = 1'b1;
endpackage

// File: rtl/xfer_chan_ctl.sv
// Module: per-channel control state (enable, abort command, end-of-flow flag).
// Assumes wr_ctl is a single-cycle strobe of a control write, and that cmd is
// this channel's nibble of that write. Reset is synchronous, active low.
module xfer_chan_ctl
    import xfer_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctl,
    input  logic [FIELD_W-1:0] cmd,
    input  logic               done,
    output logic               en_o,
    output logic               abort_o,
    output logic               flag_o
);
    logic unused_rsvd;
    logic ack_hit;

    // reserved bit of the nibble carries no function
    assign unused_rsvd = cmd[0];
    // acknowledge request from this write
    assign ack_hit     = wr_ctl & cmd[C_ACK];

    // enable tracks control writes, abort lives for one cycle, flag sets on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= 1'b0;
            abort_o <= 1'b0;
            flag_o  <= 1'b0;
        end else begin
            if (wr_ctl) begin
                en_o <= cmd[C_ENABLE];
            end
            abort_o <= wr_ctl & cmd[C_ABORT];
            flag_o  <= done | (flag_o & ~ack_hit);
        end
    end
endmodule

// File: rtl/xfer_csr_rdmux.sv
// Module: read-data selection between the control and status images.
// Assumes both images are already laid out at their bit positions.
module xfer_csr_rdmux #(
    parameter int DW = 8
) (
    input  logic          sel,
    input  logic [DW-1:0] ctl_img,
    input  logic [DW-1:0] stat_img,
    output logic [DW-1:0] rdata
);
    // combinational register read
    always_comb begin
        rdata = (sel == xfer_csr_pkg::SEL_STAT) ? stat_img : ctl_img;
    end
endmodule

// File: rtl/xfer_csr.sv
// Module: control/status register pair for a multi-channel transfer engine.
// Assumes a single-cycle write strobe, combinational reads, and engine inputs
// synchronous to clk. Each channel is one generated slice.
module xfer_csr
    import xfer_csr_pkg::*;
#(
    parameter int NCH = 2,
    localparam int DW = FIELD_W * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] chan_busy,
    input  logic [NCH-1:0] chan_src_rdy,
    input  logic [NCH-1:0] chan_dst_rdy,
    input  logic [NCH-1:0] chan_done,
    output logic [NCH-1:0] abort_pulse,
    output logic           irq
);
    logic           wr_ctl;
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] flag_q;
    logic [DW-1:0]  ctl_img;
    logic [DW-1:0]  stat_img;

    // decode of a control-register write
    assign wr_ctl = bus_wr & (bus_addr == SEL_CTL);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        xfer_chan_ctl u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (wr_ctl),
            .cmd     (bus_wdata[c*FIELD_W +: FIELD_W]),
            .done    (chan_done[c]),
            .en_o    (en_q[c]),
            .abort_o (abort_pulse[c]),
            .flag_o  (flag_q[c])
        );

        // lay out this channel's readable control and status fields
        always_comb begin
            ctl_img[c*FIELD_W +: FIELD_W]           = '0;
            ctl_img[c*FIELD_W + C_ABORT]            = abort_pulse[c];
            ctl_img[c*FIELD_W + C_ENABLE]           = en_q[c];
            stat_img[c*FIELD_W + S_DST]             = chan_dst_rdy[c];
            stat_img[c*FIELD_W + S_SRC]             = chan_src_rdy[c];
            stat_img[c*FIELD_W + S_FLAG]            = flag_q[c];
            stat_img[c*FIELD_W + S_BUSY]            = chan_busy[c];
        end
    end

    xfer_csr_rdmux #(.DW(DW)) u_rdmux (
        .sel      (bus_addr),
        .ctl_img  (ctl_img),
        .stat_img (stat_img),
        .rdata    (bus_rdata)
    );

    // combined level interrupt from enabled flags
    assign irq = |(flag_q & en_q);
endmodule

// File: rtl/xfer_csr_chk.sv
// Module: property checker for xfer_csr, attached by bind below.
// Assumes the flag and enable vectors are brought out of the channel slices.
module xfer_csr_chk
    import xfer_csr_pkg::*;
#(
    parameter int NCH = 2,
    localparam int DW = FIELD_W * NCH
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic           bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [NCH-1:0] chan_done,
    input logic [NCH-1:0] abort_pulse,
    input logic           irq,
    input logic [NCH-1:0] flag,
    input logic [NCH-1:0] enable
);
    // R1: reset clears the flags and the abort outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flag == '0 && abort_pulse == '0));

    // R8: a request needs an enabled, pending flag
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(flag & enable)));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: the abort output lasts a single cycle
        p_abort_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
            abort_pulse[c] |=> !abort_pulse[c]);
        // R3: an abort write produces the pulse on the next cycle
        p_abort_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SEL_CTL && bus_wdata[c*FIELD_W + C_ABORT])
            |=> abort_pulse[c]);
        // R4: a flag only rises after an end-of-transfer event
        p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[c]) |-> $past(chan_done[c]));
        // R9: an event always leaves the flag set
        p_done_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            chan_done[c] |=> flag[c]);
        // R5: an acknowledge with no event clears the flag
        p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SEL_CTL && bus_wdata[c*FIELD_W + C_ACK]
             && !chan_done[c]) |=> !flag[c]);
        // R6: without an acknowledge the flag holds
        p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[c] && !(bus_wr && bus_addr == SEL_CTL
                          && bus_wdata[c*FIELD_W + C_ACK])) |=> flag[c]);
    end
endmodule

bind xfer_csr xfer_csr_chk #(.NCH(NCH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .chan_done   (chan_done),
    .abort_pulse (abort_pulse),
    .irq         (irq),
    .flag        (flag_q),
    .enable      (en_q)
);

// File: tb/xfer_csr_tb_top.sv
// Bench: directed scenarios for xfer_csr, one task each, self-checking.
// Inputs change at the falling edge; outputs are sampled at the falling edge.
module xfer_csr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] chan_busy = '0;
    logic [1:0] chan_src_rdy = '0;
    logic [1:0] chan_dst_rdy = '0;
    logic [1:0] chan_done = '0;
    logic [1:0] abort_pulse;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_csr dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .chan_busy    (chan_busy),
        .chan_src_rdy (chan_src_rdy),
        .chan_dst_rdy (chan_dst_rdy),
        .chan_done    (chan_done),
        .abort_pulse  (abort_pulse),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] val);
        bus_addr = sel;
        #1;
        val = bus_rdata;
    endtask

    // one write; optional done vector on the same edge; returns half a cycle after
    task automatic wr(input logic sel, input logic [7:0] d, input logic [1:0] dn);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = sel; bus_wdata = d; chan_done = dn;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; chan_done = '0;
    endtask

    task automatic done_pulse(input logic [1:0] dn);
        @(negedge clk);
        chan_done = dn;
        @(negedge clk);
        chan_done = '0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); chk("R1 control after reset", v, 8'h00);
        rd(1'b1, v); chk("R1 status after reset", v, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        chk("R1 abort after reset", {6'd0, abort_pulse}, 8'h00);
    endtask

    task automatic t_layout;
        logic [7:0] v;
        wr(1'b0, 8'h77, 2'b00);
        rd(1'b0, v); chk("R2 enable readback, ack/reserved read 0", v, 8'h44);
        wr(1'b0, 8'h00, 2'b00);
        rd(1'b0, v); chk("R2 enables cleared", v, 8'h00);
    endtask

    task automatic t_mirror;
        logic [7:0] v;
        @(negedge clk);
        chan_busy = 2'b01; chan_src_rdy = 2'b10; chan_dst_rdy = 2'b11;
        rd(1'b1, v); chk("R7 mirror pattern A", v, 8'hC9);
        chan_busy = 2'b10; chan_src_rdy = 2'b01; chan_dst_rdy = 2'b00;
        rd(1'b1, v); chk("R7 mirror pattern B", v, 8'h14);
        chan_busy = '0; chan_src_rdy = '0; chan_dst_rdy = '0;
    endtask

    task automatic t_abort;
        logic [7:0] v;
        wr(1'b0, 8'h08, 2'b00);
        chk("R3 ch0 abort pulse", {6'd0, abort_pulse}, 8'h01);
        @(negedge clk);
        chk("R3 ch0 abort single cycle", {6'd0, abort_pulse}, 8'h00);
        rd(1'b0, v); chk("R3 ch0 abort bit reads 0", v, 8'h00);
        wr(1'b0, 8'h80, 2'b00);
        chk("R10 ch1 abort only on ch1", {6'd0, abort_pulse}, 8'h02);
        @(negedge clk);
        chk("R3 ch1 abort single cycle", {6'd0, abort_pulse}, 8'h00);
        wr(1'b0, 8'h00, 2'b00);
        chk("R3 zero write gives no pulse", {6'd0, abort_pulse}, 8'h00);
    endtask

    task automatic t_flag_ack;
        logic [7:0] v;
        done_pulse(2'b01);
        rd(1'b1, v); chk("R4 ch0 flag set", v, 8'h02);
        chk("R8 no irq while disabled", {7'd0, irq}, 8'h00);
        wr(1'b0, 8'h04, 2'b00);
        chk("R8 irq once enabled", {7'd0, irq}, 8'h01);
        rd(1'b1, v); chk("R5 ack 0 keeps flag", v, 8'h02);
        wr(1'b1, 8'h00, 2'b00);
        rd(1'b1, v); chk("R6 status write cannot clear", v, 8'h02);
        wr(1'b0, 8'h06, 2'b00);
        rd(1'b1, v); chk("R5 ack clears ch0 flag", v, 8'h00);
        chk("R8 irq drops after ack", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_no_sw_set;
        logic [7:0] v;
        wr(1'b1, 8'hFF, 2'b00);
        rd(1'b1, v); chk("R6 status write cannot set flags", v, 8'h00);
        wr(1'b0, 8'h66, 2'b00);
        rd(1'b1, v); chk("R6 control write cannot set flags", v, 8'h00);
        chk("R6 no irq from writes", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_simul;
        logic [7:0] v;
        wr(1'b0, 8'h44, 2'b00);
        done_pulse(2'b10);
        rd(1'b1, v); chk("R4 ch1 flag set", v, 8'h20);
        wr(1'b0, 8'h64, 2'b10);
        rd(1'b1, v); chk("R9 event beats ack on same edge", v, 8'h20);
        chk("R9 irq stays high", {7'd0, irq}, 8'h01);
        wr(1'b0, 8'h64, 2'b00);
        rd(1'b1, v); chk("R5 ch1 ack clears", v, 8'h00);
    endtask

    task automatic t_indep;
        logic [7:0] v;
        done_pulse(2'b11);
        rd(1'b1, v); chk("R4 both flags set", v, 8'h22);
        wr(1'b0, 8'h46, 2'b00);
        rd(1'b1, v); chk("R10 ch0 ack leaves ch1 flag", v, 8'h20);
        chk("R8 irq from ch1", {7'd0, irq}, 8'h01);
        wr(1'b0, 8'h04, 2'b00);
        chk("R8 disabling masks irq", {7'd0, irq}, 8'h00);
        rd(1'b1, v); chk("R8 masked flag still set", v, 8'h20);
        wr(1'b0, 8'h24, 2'b00);
        rd(1'b1, v); chk("R5 final ack clears", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_mirror();
        t_abort();
        t_flag_ack();
        t_no_sw_set();
        t_simul();
        t_indep();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule